// File: doc/BRIEF.md
# Multi-IO flash command sequencer

This block runs one serial-flash style transaction on a chip select, a serial clock and four IO lines. A transaction is a fixed series of phases: an opcode phase, an address phase, a dummy phase counted in clocks, a pre-data byte phase and a data phase. Any phase with a zero length is left out. The descriptor is sampled on a start pulse. It carries the phase lengths, a command-mode code, a data lane code and a read/write flag. Opcode and address bytes come in as one packed header. The pre-data byte is supplied as a single value that repeats for each pre-data byte. Write data is pulled over a ready/valid handshake, and read data is pushed out the same way.

The command-mode code sets which phases are pinned to IO0 and which use every active lane. The data lane code sets how many lanes are active (1, 2 or 4), separately from the command mode. The clock idles low, and every clock takes two system cycles: a low half and a high half. Input lines are sampled at the end of the high half. The block refuses a descriptor that cannot be carried and sets an error flag.

Top module: `mio_flash_seq`

## Requirements
- R1: After reset cs_n is 1, sclk is 0, io_oe is 0, and busy, err and rx_valid are 0.
- R2: The phases run in the fixed order opcode, address, dummy, pre-data, data, and a phase of length zero takes no cycles. Header byte k is hdr_bytes[63-8k -: 8]. Opcode bytes are header bytes 0 to cmd_bytes-1, and the address bytes follow them.
- R3: cmd_mode sets the lanes for each phase. With 0, opcode, address and pre-data use IO0 only (io_oe 0001). With 1, only opcode and address stay on IO0. With 2, only the opcode stays on IO0. With 3, every phase uses the data lanes.
- R4: data_lanes 0, 1 and 2 select one lane (IO0), two lanes (IO1:IO0) and four lanes (IO3:IO0). Each byte goes out most significant bits first, one lane-group per clock, and io_oe covers exactly the lanes in use.
- R5: The dummy phase gives dummy_clks clocks with io_oe 0. In a read, the data phase keeps io_oe 0. A one-lane read samples IO1.
- R6: Each read byte appears on rx_data with rx_valid, assembled first bits highest. It is held until rx_ready, and the next read byte does not begin while a byte is still waiting.
- R7: Every write data byte takes exactly one tx_valid/tx_ready handshake, so a transaction takes xfer_bytes handshakes in total. tx_ready is high only in the preparation cycle of a data byte, and the block waits there while tx_valid is 0.
- R8: A start with cmd_bytes+addr_bytes above 8 sets err in the next cycle and leaves cs_n high. A sum of exactly 8 is accepted.
- R9: A start with data_lanes equal to 3 is refused in the same way as R8.
- R10: A start pulse while busy is ignored and does not change err or the transaction in progress.
- R11: cs_n falls in the cycle after an accepted start. Each byte, or each dummy clock, takes one preparation cycle with sclk 0 and io_oe 0, then two cycles (sclk 0, then 1) per clock. cs_n rises in the cycle after the last high half.
- R12: An accepted start whose lengths are all zero clears err and runs no cycle with cs_n low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, samples the descriptor |
| xfer_bytes | input | 16 | Data phase length in bytes |
| cmd_bytes | input | 3 | Opcode phase length in bytes |
| addr_bytes | input | 3 | Address phase length in bytes |
| dummy_clks | input | 5 | Dummy phase length in clocks |
| pre_bytes | input | 3 | Pre-data phase length in bytes |
| cmd_mode | input | 2 | Lane assignment of the header phases |
| data_lanes | input | 2 | 0 one lane, 1 two lanes, 2 four lanes |
| read_en | input | 1 | 1 for a read data phase, 0 for a write |
| hdr_bytes | input | 64 | Opcode then address bytes, first byte highest |
| pre_byte | input | 8 | Value sent for each pre-data byte |
| busy | output | 1 | Transaction in progress |
| err | output | 1 | Last start was refused |
| sclk | output | 1 | Serial clock |
| cs_n | output | 1 | Chip select, active low |
| io_in | input | 4 | IO line input values |
| io_out | output | 4 | IO line output values |
| io_oe | output | 4 | Per-line output enables |
| tx_data | input | 8 | Write data byte |
| tx_valid | input | 1 | Write byte available |
| tx_ready | output | 1 | Write byte taken this cycle |
| rx_data | output | 8 | Read data byte |
| rx_valid | output | 1 | Read byte available |
| rx_ready | input | 1 | Read byte accepted |

## Verification
The pins react one cycle after the edge that samples start: cs_n falls, or err rises, in the next cycle. From then on, the line pattern follows a fixed schedule of one preparation cycle plus two cycles per clock for each byte. A read byte shows up on rx_valid in the cycle after its last high half. The bench turns each descriptor into a per-cycle list of expected cs_n, sclk, io_oe and io_out values. It compares the pins against that list at every falling clock edge, and it drives io_in at that same edge so the value is stable for the capture edge. Write bytes are advanced one falling edge after the edge on which tx_ready was seen, and read bytes are checked in order as rx_valid appears.

// File: rtl/mio_flash_seq_pkg.sv
package mio_flash_seq_pkg;

  localparam int CNT_W   = 16;
  localparam int CMD_W   = 3;
  localparam int ADR_W   = 3;
  localparam int DUM_W   = 5;
  localparam int PRE_W   = 3;
  localparam int LANES   = 4;
  localparam int NPHASE  = 5;

  typedef enum logic [2:0] {
    PH_CMD  = 3'd0,
    PH_ADDR = 3'd1,
    PH_DUM  = 3'd2,
    PH_PRE  = 3'd3,
    PH_DAT  = 3'd4
  } phase_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PREP = 2'd1,
    ST_LOW  = 2'd2,
    ST_HIGH = 2'd3
  } state_e;

  typedef struct packed {
    logic [CNT_W-1:0] nbytes;
    logic [CMD_W-1:0] cmd_n;
    logic [ADR_W-1:0] adr_n;
    logic [DUM_W-1:0] dum_n;
    logic [PRE_W-1:0] pre_n;
    logic [1:0]       cmode;
    logic [1:0]       lw;
    logic             rd;
  } desc_t;

  // lane code (log2 of lane count) used by a phase
  function automatic logic [1:0] phase_lw(phase_e ph, logic [1:0] cmode, logic [1:0] lw);
    logic [1:0] r;
    case (ph)
      PH_CMD:  r = (cmode == 2'd3) ? lw : 2'd0;
      PH_ADDR: r = (cmode >= 2'd2) ? lw : 2'd0;
      PH_PRE:  r = (cmode >= 2'd1) ? lw : 2'd0;
      default: r = lw;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/mio_flash_seq_phase_map.sv
module mio_flash_seq_phase_map
  import mio_flash_seq_pkg::*;
(
  input  desc_t            d,
  input  phase_e           cur,
  input  logic             from_start,
  output logic             nxt_ok,
  output phase_e           nxt,
  output logic [CNT_W-1:0] nxt_len,
  output logic [1:0]       cur_lw,
  output logic             cur_drive
);

  logic [CNT_W-1:0] len [NPHASE];

  always_comb begin
    len[0] = CNT_W'(d.cmd_n);
    len[1] = CNT_W'(d.adr_n);
    len[2] = CNT_W'(d.dum_n);
    len[3] = CNT_W'(d.pre_n);
    len[4] = d.nbytes;
  end

  // nearest non-empty phase after the current one (or the first one)
  always_comb begin
    nxt_ok  = 1'b0;
    nxt     = PH_DAT;
    nxt_len = '0;
    for (int q = NPHASE-1; q >= 0; q--) begin
      if ((len[q] != '0) && (from_start || (q > int'(cur)))) begin
        nxt_ok  = 1'b1;
        nxt     = phase_e'(3'(q));
        nxt_len = len[q];
      end
    end
  end

  always_comb begin
    cur_lw    = phase_lw(cur, d.cmode, d.lw);
    cur_drive = (cur != PH_DUM) && !((cur == PH_DAT) && d.rd);
  end

endmodule

// File: rtl/mio_flash_seq_lane_shift.sv
module mio_flash_seq_lane_shift
  import mio_flash_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_i_n,
  input  logic             load,
  input  logic [7:0]       load_byte,
  input  logic             step,
  input  logic [1:0]       lw,
  input  logic             drive,
  input  logic             active,
  input  logic [LANES-1:0] io_in,
  output logic [LANES-1:0] io_out,
  output logic [LANES-1:0] io_oe,
  output logic [7:0]       rx_nx
);

  logic [7:0]       sh_q, sh_d;
  logic [7:0]       rx_q, rx_d;
  logic [LANES-1:0] mask, bits;

  always_comb begin
    case (lw)
      2'd0:    begin mask = 4'b0001; bits = {3'b000, sh_q[7]};  rx_nx = {rx_q[6:0], io_in[1]};   end
      2'd1:    begin mask = 4'b0011; bits = {2'b00, sh_q[7:6]}; rx_nx = {rx_q[5:0], io_in[1:0]}; end
      default: begin mask = 4'b1111; bits = sh_q[7:4];          rx_nx = {rx_q[3:0], io_in};      end
    endcase
    io_oe  = (active && drive) ? mask : '0;
    io_out = bits & io_oe;
  end

  always_comb begin
    sh_d = sh_q;
    rx_d = rx_q;
    if (load) begin
      sh_d = load_byte;
      rx_d = '0;
    end else if (step) begin
      sh_d = sh_q << (3'd1 << lw);
      rx_d = rx_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      sh_q <= '0;
      rx_q <= '0;
    end else if (load || step) begin
      sh_q <= sh_d;
      rx_q <= rx_d;
    end
  end

  a_r4_oe_legal: assert property (@(posedge clk) disable iff (!rst_i_n)
    (io_oe == 4'b0000) || (io_oe == 4'b0001) || (io_oe == 4'b0011) || (io_oe == 4'b1111));

endmodule

// File: rtl/mio_flash_seq.sv
module mio_flash_seq
  import mio_flash_seq_pkg::*;
#(
  parameter int HDR_BYTES = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [15:0] xfer_bytes,
  input  logic [2:0]  cmd_bytes,
  input  logic [2:0]  addr_bytes,
  input  logic [4:0]  dummy_clks,
  input  logic [2:0]  pre_bytes,
  input  logic [1:0]  cmd_mode,
  input  logic [1:0]  data_lanes,
  input  logic        read_en,
  input  logic [63:0] hdr_bytes,
  input  logic [7:0]  pre_byte,
  output logic        busy,
  output logic        err,
  output logic        sclk,
  output logic        cs_n,
  input  logic [3:0]  io_in,
  output logic [3:0]  io_out,
  output logic [3:0]  io_oe,
  input  logic [7:0]  tx_data,
  input  logic        tx_valid,
  output logic        tx_ready,
  output logic [7:0]  rx_data,
  output logic        rx_valid,
  input  logic        rx_ready
);

  localparam int HDR_W = HDR_BYTES * 8;
  localparam int IDX_W = $clog2(HDR_BYTES);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i_n = rst_sync[1];

  desc_t            desc_in, desc_q, d_cur;
  logic [HDR_W-1:0] hdr_q;
  logic [7:0]       pre_q;
  state_e           st_q, st_d;
  phase_e           ph_q, ph_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [3:0]       slot_q, slot_d;
  logic [IDX_W-1:0] hidx_q, hidx_d;
  logic             err_q, err_d;
  logic [7:0]       rxd_q, rxd_d;
  logic             rxv_q, rxv_d;
  logic             latch_en, load, step, rx_push, bad, go;
  logic             nxt_ok, cur_drive, active;
  phase_e           nxt;
  logic [CNT_W-1:0] nxt_len;
  logic [1:0]       cur_lw;
  logic [7:0]       load_byte, hdr_byte, rx_nx;

  assign desc_in = '{nbytes: xfer_bytes, cmd_n: cmd_bytes, adr_n: addr_bytes,
                     dum_n: dummy_clks, pre_n: pre_bytes, cmode: cmd_mode,
                     lw: data_lanes, rd: read_en};
  assign d_cur   = (st_q == ST_IDLE) ? desc_in : desc_q;
  assign bad     = (({1'b0, cmd_bytes} + {1'b0, addr_bytes}) > 4'(HDR_BYTES)) ||
                   (data_lanes == 2'd3);

  mio_flash_seq_phase_map u_map (
    .d          (d_cur),
    .cur        (ph_q),
    .from_start (st_q == ST_IDLE),
    .nxt_ok     (nxt_ok),
    .nxt        (nxt),
    .nxt_len    (nxt_len),
    .cur_lw     (cur_lw),
    .cur_drive  (cur_drive)
  );

  assign hdr_byte = hdr_q[(HDR_W - 1 - 8 * int'(hidx_q)) -: 8];
  assign tx_ready = (st_q == ST_PREP) && (ph_q == PH_DAT) && !desc_q.rd;
  assign go       = !((ph_q == PH_DAT) && !desc_q.rd && !tx_valid) &&
                    !((ph_q == PH_DAT) && desc_q.rd && rxv_q && !rx_ready);
  assign active   = (st_q == ST_LOW) || (st_q == ST_HIGH);

  always_comb begin
    case (ph_q)
      PH_CMD, PH_ADDR: load_byte = hdr_byte;
      PH_PRE:          load_byte = pre_q;
      PH_DAT:          load_byte = tx_data;
      default:         load_byte = 8'h00;
    endcase
  end

  // next-state logic
  always_comb begin
    st_d     = st_q;
    ph_d     = ph_q;
    cnt_d    = cnt_q;
    slot_d   = slot_q;
    hidx_d   = hidx_q;
    err_d    = err_q;
    latch_en = 1'b0;
    load     = 1'b0;
    step     = 1'b0;
    rx_push  = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          if (bad) begin
            err_d = 1'b1;
          end else begin
            err_d    = 1'b0;
            latch_en = 1'b1;
            hidx_d   = '0;
            if (nxt_ok) begin
              st_d  = ST_PREP;
              ph_d  = nxt;
              cnt_d = nxt_len;
            end
          end
        end
      end
      ST_PREP: begin
        if (go) begin
          load   = 1'b1;
          slot_d = (ph_q == PH_DUM) ? 4'd1 : (4'd8 >> cur_lw);
          st_d   = ST_LOW;
          if ((ph_q == PH_CMD) || (ph_q == PH_ADDR)) hidx_d = hidx_q + 1'b1;
        end
      end
      ST_LOW: st_d = ST_HIGH;
      default: begin
        step   = 1'b1;
        slot_d = slot_q - 4'd1;
        if (slot_q != 4'd1) begin
          st_d = ST_LOW;
        end else begin
          rx_push = (ph_q == PH_DAT) && desc_q.rd;
          if (cnt_q != CNT_W'(1)) begin
            cnt_d = cnt_q - CNT_W'(1);
            st_d  = ST_PREP;
          end else if (nxt_ok) begin
            ph_d  = nxt;
            cnt_d = nxt_len;
            st_d  = ST_PREP;
          end else begin
            st_d = ST_IDLE;
          end
        end
      end
    endcase
  end

  always_comb begin
    rxv_d = rx_push ? 1'b1 : (rx_ready ? 1'b0 : rxv_q);
    rxd_d = rx_push ? rx_nx : rxd_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      st_q   <= ST_IDLE;
      ph_q   <= PH_CMD;
      cnt_q  <= '0;
      slot_q <= '0;
      hidx_q <= '0;
      err_q  <= 1'b0;
      rxv_q  <= 1'b0;
      rxd_q  <= '0;
    end else begin
      st_q   <= st_d;
      ph_q   <= ph_d;
      cnt_q  <= cnt_d;
      slot_q <= slot_d;
      hidx_q <= hidx_d;
      err_q  <= err_d;
      rxv_q  <= rxv_d;
      if (rx_push) rxd_q <= rxd_d;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      desc_q <= '0;
      hdr_q  <= '0;
      pre_q  <= '0;
    end else if (latch_en) begin
      desc_q <= desc_in;
      hdr_q  <= hdr_bytes;
      pre_q  <= pre_byte;
    end
  end

  mio_flash_seq_lane_shift u_lanes (
    .clk       (clk),
    .rst_i_n   (rst_i_n),
    .load      (load),
    .load_byte (load_byte),
    .step      (step),
    .lw        (cur_lw),
    .drive     (cur_drive),
    .active    (active),
    .io_in     (io_in),
    .io_out    (io_out),
    .io_oe     (io_oe),
    .rx_nx     (rx_nx)
  );

  assign busy     = (st_q != ST_IDLE);
  assign cs_n     = (st_q == ST_IDLE);
  assign sclk     = (st_q == ST_HIGH);
  assign err      = err_q;
  assign rx_valid = rxv_q;
  assign rx_data  = rxd_q;

  a_r11_clk_only_selected: assert property (@(posedge clk) disable iff (!rst_i_n)
    sclk |-> !cs_n);
  a_r11_clk_half: assert property (@(posedge clk) disable iff (!rst_i_n)
    sclk |=> !sclk);
  a_r5_dummy_released: assert property (@(posedge clk) disable iff (!rst_i_n)
    (active && (ph_q == PH_DUM)) |-> (io_oe == 4'b0000));
  a_r3_opcode_single: assert property (@(posedge clk) disable iff (!rst_i_n)
    (active && (ph_q == PH_CMD) && (desc_q.cmode != 2'd3)) |-> (io_oe == 4'b0001));
  a_r6_rx_hold: assert property (@(posedge clk) disable iff (!rst_i_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));
  a_r7_one_take: assert property (@(posedge clk) disable iff (!rst_i_n)
    (tx_valid && tx_ready) |=> !tx_ready);
  a_r8_err_no_select: assert property (@(posedge clk) disable iff (!rst_i_n)
    $rose(err) |-> cs_n);
  a_r10_desc_held: assert property (@(posedge clk) disable iff (!rst_i_n)
    (busy && $past(busy)) |-> $stable(desc_q));

endmodule

// File: tb/mio_flash_seq_tb_top.sv
`timescale 1ns/1ps
module mio_flash_seq_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [15:0] xfer_bytes;
  logic [2:0]  cmd_bytes, addr_bytes, pre_bytes;
  logic [4:0]  dummy_clks;
  logic [1:0]  cmd_mode, data_lanes;
  logic        read_en;
  logic [63:0] hdr_bytes;
  logic [7:0]  pre_byte;
  logic        busy, err, sclk, cs_n;
  logic [3:0]  io_in, io_out, io_oe;
  logic [7:0]  tx_data, rx_data;
  logic        tx_valid, tx_ready, rx_valid, rx_ready;

  int tests = 0;
  int fails = 0;

  logic [9:0] exp_q[$];
  logic [3:0] in_q[$];
  string      tag_q[$];
  logic [7:0] rx_exp[$];
  logic [7:0] tx_bytes[$];
  int         tx_idx;

  always #2 clk = ~clk;

  mio_flash_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .xfer_bytes(xfer_bytes),
    .cmd_bytes(cmd_bytes), .addr_bytes(addr_bytes), .dummy_clks(dummy_clks),
    .pre_bytes(pre_bytes), .cmd_mode(cmd_mode), .data_lanes(data_lanes),
    .read_en(read_en), .hdr_bytes(hdr_bytes), .pre_byte(pre_byte),
    .busy(busy), .err(err), .sclk(sclk), .cs_n(cs_n), .io_in(io_in),
    .io_out(io_out), .io_oe(io_oe), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready)
  );

  task automatic check(bit ok, string req, string what, int act, int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  function automatic int lane_of(int ph, int cm, int dl);
    if (ph == 0) return (cm == 3) ? dl : 0;
    if (ph == 1) return (cm >= 2) ? dl : 0;
    if (ph == 3) return (cm >= 1) ? dl : 0;
    return dl;
  endfunction

  task automatic push(bit csn, bit sck, int oe, int o, int inb, string tg);
    exp_q.push_back({csn, sck, 4'(oe), 4'(o)});
    in_q.push_back(4'(inb));
    tag_q.push_back(tg);
  endtask

  // one byte (or one dummy clock): prep cycle then low/high pairs
  task automatic add_unit(int lw, bit drv, int b, int rb, bit rdcap, bit dummy, string tg);
    int w, m, c, r, inb;
    push(0, 0, 0, 0, 0, "R11");
    if (dummy) begin
      push(0, 0, 0, 0, 0, tg);
      push(0, 1, 0, 0, 0, tg);
    end else begin
      w = 1 << lw;
      m = (1 << w) - 1;
      for (int s = 0; s < 8 / w; s++) begin
        c   = (b  >> (8 - w * (s + 1))) & m;
        r   = (rb >> (8 - w * (s + 1))) & m;
        inb = rdcap ? ((lw == 0) ? (r << 1) : r) : 0;
        push(0, 0, drv ? m : 0, drv ? c : 0, inb, tg);
        push(0, 1, drv ? m : 0, drv ? c : 0, inb, tg);
      end
    end
  endtask

  task automatic run_txn(int nb, int cn, int an, int dn, int pn, int cm, int dl,
                         bit rd, logic [63:0] hdr, logic [7:0] pb, int inj, string tg);
    bit pending;
    exp_q.delete(); in_q.delete(); tag_q.delete(); rx_exp.delete(); tx_bytes.delete();
    for (int k = 0; k < cn + an; k++)
      add_unit(lane_of(k < cn ? 0 : 1, cm, dl), 1, int'(hdr >> (56 - 8 * k)) & 255, 0, 0, 0,
               (k < cn) ? "R3" : "R2");
    for (int k = 0; k < dn; k++) add_unit(0, 0, 0, 0, 0, 1, "R5");
    for (int k = 0; k < pn; k++) add_unit(lane_of(3, cm, dl), 1, int'(pb), 0, 0, 0, "R3");
    for (int k = 0; k < nb; k++) begin
      if (rd) begin
        rx_exp.push_back(8'hC3 ^ 8'(k * 53));
        add_unit(dl, 0, 0, int'(rx_exp[k]), 1, 0, "R5");
      end else begin
        tx_bytes.push_back(8'h3C + 8'(k * 29));
        add_unit(dl, 1, int'(tx_bytes[k]), 0, 0, 0, "R4");
      end
    end
    push(1, 0, 0, 0, 0, "R11");
    push(1, 0, 0, 0, 0, "R11");

    tx_idx = 0; pending = 0;
    @(negedge clk);
    xfer_bytes = 16'(nb); cmd_bytes = 3'(cn); addr_bytes = 3'(an); dummy_clks = 5'(dn);
    pre_bytes = 3'(pn); cmd_mode = 2'(cm); data_lanes = 2'(dl); read_en = rd;
    hdr_bytes = hdr; pre_byte = pb;
    tx_data = (tx_bytes.size() > 0) ? tx_bytes[0] : 8'h00;
    start = 1'b1;
    for (int i = 0; i < exp_q.size(); i++) begin
      @(negedge clk);
      if (i == 0) start = 1'b0;
      check({cs_n, sclk, io_oe, io_out} == exp_q[i], tag_q[i],
            $sformatf("%s cycle %0d pins", tg, i), int'({cs_n, sclk, io_oe, io_out}), int'(exp_q[i]));
      io_in = in_q[i];
      if (rx_valid) begin
        if (rx_exp.size() == 0) check(0, "R6", "unexpected rx byte", int'(rx_data), 0);
        else begin
          logic [7:0] e;
          e = rx_exp.pop_front();
          check(rx_data == e, "R6", {tg, " rx byte"}, int'(rx_data), int'(e));
        end
      end
      if (pending) begin tx_idx++; pending = 0; end
      tx_data = (tx_idx < tx_bytes.size()) ? tx_bytes[tx_idx] : 8'h00;
      if (tx_ready && tx_valid) pending = 1;
      if (i == inj) begin start = 1'b1; cmd_bytes = 3'd7; addr_bytes = 3'd7; end
      if (inj >= 0 && i == inj + 1) begin start = 1'b0; cmd_bytes = 3'(cn); addr_bytes = 3'(an); end
    end
    check(rx_exp.size() == 0, "R6", {tg, " rx bytes left"}, rx_exp.size(), 0);
    check(tx_idx == (rd ? 0 : nb), "R7", {tg, " write handshakes"}, tx_idx, rd ? 0 : nb);
    check(err == 1'b0, "R10", {tg, " err after run"}, int'(err), 0);
  endtask

  task automatic refuse(int cn, int an, int dl, string req);
    @(negedge clk);
    cmd_bytes = 3'(cn); addr_bytes = 3'(an); data_lanes = 2'(dl);
    xfer_bytes = 16'd1; dummy_clks = 5'd0; pre_bytes = 3'd0; read_en = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(err == 1'b1, req, "err after refused start", int'(err), 1);
    for (int i = 0; i < 3; i++) begin
      check(cs_n == 1'b1 && busy == 1'b0, req, "stays idle", int'({cs_n, busy}), 2);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", tests, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; xfer_bytes = '0; cmd_bytes = '0; addr_bytes = '0;
    dummy_clks = '0; pre_bytes = '0; cmd_mode = '0; data_lanes = '0; read_en = 1'b0;
    hdr_bytes = '0; pre_byte = '0; io_in = '0; tx_data = '0; tx_valid = 1'b1; rx_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check(cs_n == 1 && sclk == 0 && io_oe == 0 && busy == 0 && err == 0 && rx_valid == 0,
          "R1", "reset outputs", int'({cs_n, sclk, io_oe, busy, err, rx_valid}), 9'h100);

    // R4 one-lane write, mode 0, start pulses mid-run ignored (R10)
    run_txn(2, 1, 3, 0, 0, 0, 0, 0, 64'h9F12_3456_0000_0000, 8'h00, 20, "single write");
    // R3/R5 mode 1 four-lane read with dummy and pre-data
    run_txn(3, 1, 3, 4, 1, 1, 2, 1, 64'hEBA1_B2C3_0000_0000, 8'h5A, -1, "quad read m1");
    // R3 mode 2 two-lane write with dummy
    run_txn(2, 2, 4, 2, 0, 2, 1, 0, 64'h3BC4_1122_3344_0000, 8'h00, -1, "dual write m2");
    // R2 mode 3, address and dummy skipped
    run_txn(1, 1, 0, 0, 2, 3, 2, 0, 64'h6B00_0000_0000_0000, 8'hA7, -1, "quad m3 skip");
    // R5 one-lane read sampled on IO1
    run_txn(2, 1, 1, 0, 0, 0, 0, 1, 64'h0355_0000_0000_0000, 8'h00, -1, "single read");

    // R8 header over limit, R12 empty descriptor clears err
    refuse(5, 4, 0, "R8");
    @(negedge clk);
    xfer_bytes = '0; cmd_bytes = '0; addr_bytes = '0; dummy_clks = '0; pre_bytes = '0;
    data_lanes = '0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(err == 1'b0, "R12", "err cleared by empty start", int'(err), 0);
    for (int i = 0; i < 3; i++) begin
      check(cs_n == 1'b1 && busy == 1'b0, "R12", "empty start runs nothing", int'({cs_n, busy}), 2);
      @(negedge clk);
    end
    // R9 lane code 3 refused
    refuse(1, 1, 3, "R9");
    // R8 boundary: exactly 8 header bytes accepted
    run_txn(1, 4, 4, 0, 0, 3, 2, 0, 64'h0123_4567_89AB_CDEF, 8'h00, -1, "R8 eight bytes");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule